// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a segment register number and an offset into a physical address. A mode input picks one of two formation rules. In real mode, the chosen segment register holds a plain paragraph value, and the address is that value shifted left by four plus a 16-bit offset. In protected mode, the segment register is loaded with a selector. The selector indexes an 8-byte entry in either a global table or a local table. The block reads that entry through a simple memory read port and keeps the resulting base and limit in a hidden per-register cache. Later accesses form `base + offset` from that cache, so they do not go back to memory.

Each table has a base register and a limit register that software loads. A protected-mode load is refused with a fault pulse in two cases: the selector has any of its low three bits set, or its entry runs past the chosen table's limit. An access whose offset is greater than the cached limit produces a fault instead of an address. A 2-bit index selects one of four independent segment registers.

Top module: `segXlate`

## Requirements
- R1: After reset, `busy`, `memReq`, `physValid`, `accFault` and `ldFault` are low. Every real-mode segment value is 0. Every cache entry holds base 0 and limit 0.
- R2: A real-mode access (`protMode`=0, `accEn`=1) raises `physValid` one cycle later with `physAddr` = segment value × 16 + `accOff[15:0]`. Bits 31:16 of the offset are ignored, and a real-mode access never faults.
- R3: A real-mode load (`ldEn`=1, `protMode`=0) writes `ldSel` into segment value `ldSeg` at the next edge. It starts no memory read and does not raise `busy`.
- R4: A protected-mode load whose selector has a nonzero value in bits 2:0 gives a one-cycle `ldFault` pulse in the next cycle. It starts no read and leaves the cache unchanged.
- R5: `ldTable`=0 selects the global table and 1 selects the local table. Both tables are written through `tblWrEn`/`tblWrSel`/`tblWrBase`/`tblWrLimit`. A protected load faults as in R4 when (selector with bits 2:0 cleared) + 7 is greater than the table limit; a value equal to the limit is accepted.
- R6: An accepted protected load raises `busy` (and `memReq`, which equals it) from the next cycle until the cycle after the second read returns. The first read address is the table base + the entry offset, and its data is the segment base. The second read is at that address + 4, and its data is the segment limit. Each request is held with a stable address until `memValid` is seen.
- R7: `ldEn` is ignored while `busy` is high, in both modes.
- R8: A protected access raises `physValid` the next cycle with `physAddr` = cached base + `accOff` (mod 2^32) when `accOff` ≤ cached limit. Otherwise it raises `accFault` and not `physValid`. An access in the same cycle as a cache write sees the old contents.
- R9: The four segment registers (`ldSeg`/`accSeg` index 0–3) hold separate real-mode values and cache entries. A load to one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| protMode | input | 1 | 1 = protected mode, 0 = real mode |
| tblWrEn | input | 1 | Write a table base/limit pair |
| tblWrSel | input | 1 | Table written: 0 global, 1 local |
| tblWrBase | input | 32 | Table base address to store |
| tblWrLimit | input | 16 | Table limit (last valid byte offset) |
| ldEn | input | 1 | Segment register load request |
| ldSeg | input | 2 | Segment register being loaded |
| ldSel | input | 16 | Selector or real-mode segment value |
| ldTable | input | 1 | Table the selector indexes: 0 global, 1 local |
| busy | output | 1 | Descriptor fetch in progress |
| ldFault | output | 1 | Load refused (protection fault) |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read address |
| memValid | input | 1 | Read data valid |
| memData | input | 32 | Read data |
| accEn | input | 1 | Address formation request |
| accSeg | input | 2 | Segment register used by the access |
| accOff | input | 32 | Offset |
| physValid | output | 1 | Physical address valid |
| physAddr | output | 32 | Physical address |
| accFault | output | 1 | Access beyond segment limit |

## Verification
The hardest situations to reach are the overlaps with an open fetch. These are a second load, which must be dropped, and an access to the register being fetched, which must still see the old cache entry. Both can occur only while `busy` is high. The bench's memory responder delays `memValid` by a programmable number of cycles, which holds the fetch open so these inputs can be driven inside the window. A register that was never loaded keeps base 0 and limit 0, so an access at offset 1 faults. That makes any stray cache write show up at the ports.

// File: rtl/segXlatePkg.sv
package segXlatePkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LO,
    ST_HI
  } fetchState_t;

  typedef struct packed {
    logic latchEntry;
    logic capBase;
    logic wrCache;
    logic wrReal;
    logic readHi;
  } dpStrobe_t;
endpackage

// File: rtl/segXlateCtrl.sv
module segXlateCtrl
  import segXlatePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ldEn,
  input  logic       protMode,
  input  logic       selLegal,
  input  logic       memValid,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       memReq,
  output logic       ldFault
);
  fetchState_t state;
  logic        idle;

  assign idle = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ldFault <= 1'b0;
    end else begin
      ldFault <= idle && ldEn && protMode && !selLegal;
      unique case (state)
        ST_IDLE: if (ldEn && protMode && selLegal) state <= ST_LO;
        ST_LO:   if (memValid) state <= ST_HI;
        ST_HI:   if (memValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.latchEntry = idle && ldEn && protMode && selLegal;
    strobe.wrReal     = idle && ldEn && !protMode;
    strobe.capBase    = (state == ST_LO) && memValid;
    strobe.wrCache    = (state == ST_HI) && memValid;
    strobe.readHi     = (state == ST_HI);
  end

  assign busy   = !idle;
  assign memReq = !idle;
endmodule

// File: rtl/segXlateDp.sv
module segXlateDp
  import segXlatePkg::*;
#(
  parameter int AW   = 32,
  parameter int SELW = 16,
  parameter int TLW  = 16,
  parameter int NSEG = 4,
  localparam int SEGW = $clog2(NSEG),
  localparam int CW   = ((SELW > TLW) ? SELW : TLW) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic            protMode,
  input  logic            tblWrEn,
  input  logic            tblWrSel,
  input  logic [AW-1:0]   tblWrBase,
  input  logic [TLW-1:0]  tblWrLimit,
  input  logic [SEGW-1:0] ldSeg,
  input  logic [SELW-1:0] ldSel,
  input  logic            ldTable,
  input  logic [AW-1:0]   memData,
  input  logic            accEn,
  input  logic [SEGW-1:0] accSeg,
  input  logic [AW-1:0]   accOff,
  output logic            selLegal,
  output logic [AW-1:0]   memAddr,
  output logic            physValid,
  output logic [AW-1:0]   physAddr,
  output logic            accFault
);
  logic [AW-1:0]   tblBase [2];
  logic [TLW-1:0]  tblLim  [2];
  logic [SELW-1:0] segVal  [NSEG];
  logic [AW-1:0]   cBase   [NSEG];
  logic [AW-1:0]   cLim    [NSEG];
  logic [SEGW-1:0] pendSeg;
  logic [AW-1:0]   entryAddr;
  logic [AW-1:0]   baseHold;
  logic [SELW-1:0] entryOff;
  logic [CW-1:0]   lastByte;

  assign entryOff = {ldSel[SELW-1:3], 3'b000};
  assign lastByte = CW'(entryOff) + CW'(7);
  assign selLegal = (ldSel[2:0] == 3'b000) && (lastByte <= CW'(tblLim[ldTable]));
  assign memAddr  = entryAddr + (strobe.readHi ? AW'(4) : AW'(0));

  for (genvar t = 0; t < 2; t++) begin : gTbl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tblBase[t] <= '0;
        tblLim[t]  <= '0;
      end else if (tblWrEn && (tblWrSel == 1'(t))) begin
        tblBase[t] <= tblWrBase;
        tblLim[t]  <= tblWrLimit;
      end
    end
  end

  for (genvar s = 0; s < NSEG; s++) begin : gSeg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        segVal[s] <= '0;
        cBase[s]  <= '0;
        cLim[s]   <= '0;
      end else begin
        if (strobe.wrReal && (ldSeg == SEGW'(s))) segVal[s] <= ldSel;
        if (strobe.wrCache && (pendSeg == SEGW'(s))) begin
          cBase[s] <= baseHold;
          cLim[s]  <= memData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendSeg   <= '0;
      entryAddr <= '0;
      baseHold  <= '0;
    end else begin
      if (strobe.latchEntry) begin
        pendSeg   <= ldSeg;
        entryAddr <= tblBase[ldTable] + AW'(entryOff);
      end
      if (strobe.capBase) baseHold <= memData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physValid <= 1'b0;
      physAddr  <= '0;
      accFault  <= 1'b0;
    end else begin
      physValid <= 1'b0;
      accFault  <= 1'b0;
      if (accEn) begin
        if (!protMode) begin
          physValid <= 1'b1;
          physAddr  <= AW'({segVal[accSeg], 4'b0000}) + AW'(accOff[15:0]);
        end else if (accOff > cLim[accSeg]) begin
          accFault <= 1'b1;
        end else begin
          physValid <= 1'b1;
          physAddr  <= cBase[accSeg] + accOff;
        end
      end
    end
  end
endmodule

// File: rtl/segXlate.sv
module segXlate
  import segXlatePkg::*;
#(
  parameter int AW   = 32,
  parameter int SELW = 16,
  parameter int TLW  = 16,
  parameter int NSEG = 4,
  localparam int SEGW = $clog2(NSEG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            protMode,
  input  logic            tblWrEn,
  input  logic            tblWrSel,
  input  logic [AW-1:0]   tblWrBase,
  input  logic [TLW-1:0]  tblWrLimit,
  input  logic            ldEn,
  input  logic [SEGW-1:0] ldSeg,
  input  logic [SELW-1:0] ldSel,
  input  logic            ldTable,
  output logic            busy,
  output logic            ldFault,
  output logic            memReq,
  output logic [AW-1:0]   memAddr,
  input  logic            memValid,
  input  logic [AW-1:0]   memData,
  input  logic            accEn,
  input  logic [SEGW-1:0] accSeg,
  input  logic [AW-1:0]   accOff,
  output logic            physValid,
  output logic [AW-1:0]   physAddr,
  output logic            accFault
);
  dpStrobe_t strobe;
  logic      selLegal;

  segXlateCtrl uCtrl (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .protMode(protMode),
    .selLegal(selLegal), .memValid(memValid), .strobe(strobe),
    .busy(busy), .memReq(memReq), .ldFault(ldFault)
  );

  segXlateDp #(.AW(AW), .SELW(SELW), .TLW(TLW), .NSEG(NSEG)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .protMode(protMode),
    .tblWrEn(tblWrEn), .tblWrSel(tblWrSel), .tblWrBase(tblWrBase),
    .tblWrLimit(tblWrLimit), .ldSeg(ldSeg), .ldSel(ldSel), .ldTable(ldTable),
    .memData(memData), .accEn(accEn), .accSeg(accSeg), .accOff(accOff),
    .selLegal(selLegal), .memAddr(memAddr), .physValid(physValid),
    .physAddr(physAddr), .accFault(accFault)
  );
endmodule

// File: rtl/segXlateChk.sv
module segXlateChk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          protMode,
  input logic          ldEn,
  input logic          accEn,
  input logic          busy,
  input logic          memReq,
  input logic          memValid,
  input logic [AW-1:0] memAddr,
  input logic          physValid,
  input logic          accFault,
  input logic          ldFault
);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ldEn && protMode));

  // R4
  ld_fault_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldFault |-> ($past(ldEn && protMode && !busy) && !busy));

  // R8
  acc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(physValid && accFault));

  // R8
  acc_fault_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    accFault |-> $past(protMode && accEn));

  // R2
  acc_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    physValid |-> $past(accEn));
endmodule

bind segXlate segXlateChk #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .protMode(protMode), .ldEn(ldEn), .accEn(accEn),
  .busy(busy), .memReq(memReq), .memValid(memValid), .memAddr(memAddr),
  .physValid(physValid), .accFault(accFault), .ldFault(ldFault)
);

// File: tb/segXlate_test.sv
module segXlate_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        protMode = 1'b0;
  logic        tblWrEn = 1'b0, tblWrSel = 1'b0;
  logic [31:0] tblWrBase = '0;
  logic [15:0] tblWrLimit = '0;
  logic        ldEn = 1'b0, ldTable = 1'b0;
  logic [1:0]  ldSeg = '0;
  logic [15:0] ldSel = '0;
  logic        busy, ldFault, memReq, physValid, accFault;
  logic [31:0] memAddr, physAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        accEn = 1'b0;
  logic [1:0]  accSeg = '0;
  logic [31:0] accOff = '0;

  int checks = 0, errors = 0, lat = 0, cnt = 0, cycles = 0;
  bit started = 0, done = 0;
  logic [31:0] memImg [logic [31:0]];

  always #5 clk = ~clk;

  segXlate uut (.*);

  // behavioural reference model
  int unsigned mSeg [4], mBase [4], mLim [4], mTblB [2], mTblL [2];
  int unsigned mEntry, mTmp, mPend, ePhys;
  int  phase;
  bit  eBusy, eValid, eAccF, eLdF;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mSeg[i] = 0; mBase[i] = 0; mLim[i] = 0; end
      for (int i = 0; i < 2; i++) begin mTblB[i] = 0; mTblL[i] = 0; end
      phase = 0; mEntry = 0; eBusy = 0; eValid = 0; eAccF = 0; eLdF = 0; ePhys = 0;
    end else begin
      eValid = 0; eAccF = 0; eLdF = 0;
      if (accEn) begin
        if (!protMode) begin
          eValid = 1; ePhys = mSeg[accSeg] * 16 + int'(accOff[15:0]);
        end else if (accOff > mLim[accSeg]) eAccF = 1;
        else begin eValid = 1; ePhys = mBase[accSeg] + accOff; end
      end
      if (phase == 1) begin
        if (memValid) begin mTmp = memData; phase = 2; end
      end else if (phase == 2) begin
        if (memValid) begin mBase[mPend] = mTmp; mLim[mPend] = memData; phase = 0; end
      end else if (ldEn) begin
        if (!protMode) mSeg[ldSeg] = ldSel;
        else if (ldSel[2:0] != 0 || (int'(ldSel) & ~7) + 7 > int'(mTblL[ldTable])) eLdF = 1;
        else begin phase = 1; mPend = ldSeg; mEntry = mTblB[ldTable] + (ldSel & ~16'h7); end
      end
      if (tblWrEn) begin mTblB[tblWrSel] = tblWrBase; mTblL[tblWrSel] = tblWrLimit; end
      eBusy = (phase != 0);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk("R6 busy", busy, eBusy);
      chk("R6 memReq", memReq, eBusy);
      if (eBusy) chk("R6 memAddr", memAddr, mEntry + (phase == 2 ? 4 : 0));
      chk("R2 or R8 physValid", physValid, eValid);
      if (eValid) chk("R2 or R8 physAddr", physAddr, ePhys);
      chk("R8 accFault", accFault, eAccF);
      chk("R4 or R5 ldFault", ldFault, eLdF);
    end
  end

  // memory responder with programmable latency
  always @(negedge clk) begin
    if (memValid) begin memValid = 0; cnt = 0; end
    else if (memReq) begin
      if (cnt >= lat) begin
        memValid = 1;
        memData = memImg.exists(memAddr) ? memImg[memAddr] : 32'h0;
      end else cnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic setTbl(bit sel, logic [31:0] b, logic [15:0] l);
    tblWrEn = 1; tblWrSel = sel; tblWrBase = b; tblWrLimit = l; tick(); tblWrEn = 0;
  endtask

  task automatic load(logic [1:0] s, logic [15:0] v, bit tbl);
    ldEn = 1; ldSeg = s; ldSel = v; ldTable = tbl; tick(); ldEn = 0;
  endtask

  task automatic access(logic [1:0] s, logic [31:0] o);
    accEn = 1; accSeg = s; accOff = o; tick(); accEn = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 100 && busy; i++) tick();
  endtask

  initial begin
    repeat (3) tick();
    started = 1;
    chk("R1 busy", busy, 0);
    chk("R1 physValid", physValid, 0);
    rstN = 1; tick();
    // R1: reset contents
    access(2, 32'h10);  chk("R1 real seg zero", physAddr, 32'h10);
    protMode = 1;
    access(3, 0);       chk("R1 cache base zero", physAddr, 0);
    access(3, 1);       chk("R1 cache limit zero", accFault, 1);
    protMode = 0;
    // R3 / R2
    load(1, 16'h1234, 0); chk("R3 no busy", busy, 0);
    access(1, 32'hFFFF_5678); chk("R2 real addr", physAddr, 32'h179B8);
    // tables
    setTbl(0, 32'h1000, 16'h2F);
    setTbl(1, 32'h8000, 16'h0F);
    memImg[32'h1010] = 32'h0040_0000; memImg[32'h1014] = 32'h0000_FFFF;
    memImg[32'h1028] = 32'h1234_0000; memImg[32'h102C] = 32'h10;
    memImg[32'h8008] = 32'hFFFF_FFF0; memImg[32'h800C] = 32'hFFFF_FFFF;
    protMode = 1; lat = 0;
    load(0, 16'h10, 0); chk("R6 busy after load", busy, 1);
    waitIdle();
    access(0, 32'h100);   chk("R8 prot addr", physAddr, 32'h0040_0100);
    access(0, 32'hFFFF);  chk("R8 limit edge", physValid, 1);
    access(0, 32'h10000); chk("R8 over limit", accFault, 1);
    // R5 boundary entry, R7 load during busy, old cache during fetch
    lat = 3;
    load(1, 16'h28, 0);
    load(2, 16'h08, 1);
    access(1, 0); chk("R8 old cache during fetch", physAddr, 0);
    waitIdle();
    access(1, 32'h10); chk("R5 boundary accepted", physAddr, 32'h1234_0010);
    access(1, 32'h11); chk("R8 over limit seg1", accFault, 1);
    access(2, 1);      chk("R7 load ignored while busy", accFault, 1);
    // R5 index over limit, R4 low bits
    load(2, 16'h30, 0); chk("R5 global index over", ldFault, 1);
    load(2, 16'h10, 1); chk("R5 local index over", ldFault, 1);
    load(2, 16'h0B, 0); chk("R4 low bits set", ldFault, 1);
    chk("R4 no fetch", busy, 0);
    access(2, 1);       chk("R4 cache unchanged", accFault, 1);
    // local table, wrap, R9 independence
    lat = 1;
    load(2, 16'h08, 1); waitIdle();
    access(2, 32'h20); chk("R8 wrap", physAddr, 32'h10);
    access(0, 32'h100); chk("R9 seg0 kept", physAddr, 32'h0040_0100);
    protMode = 0;
    access(1, 0); chk("R9 real value kept", physAddr, 32'h12340);
    tick(); tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule